// File: doc/BRIEF.md
# Watchdog Timeout Capture by Ramp Measurement

This block learns the watchdog timeout from an external timing capacitor. An analog current source charges the capacitor while the block asserts its ramp-enable output. A comparator reports when the ramp crosses its threshold. The block counts whole ticks of the watchdog time base until that happens. The floor of the elapsed tick count becomes the stored timeout code, which the watchdog uses from then on.

A measurement run begins each time the system reset status goes inactive. If system reset returns before the run ends, the run is abandoned and the ramp is discharged. The next release starts counting again from zero. Results outside the valid window map to two special codes. A ramp that trips too early gives code zero. A ramp that never trips within the maximum gives the all-ones code. An open capacitor therefore yields a zero timeout, which holds the system in continuous reset. An oversized or grounded capacitor yields the disabled (infinite) timeout.

Top module: `wrc_ramp_capture`

## Requirements
- R1: While `rst_n` is low and afterwards until a run starts, `ramp_run` is 0, `code_valid` is 0 and `tmo_code` is 0.
- R2: When `sys_rst_active` is sampled low while the block is idle, `ramp_run` rises at the next clock edge.
- R3: A completed normal run stores in `tmo_code` the number of `tick` pulses sampled while `ramp_run` was 1. `ramp_trip` passes through `SYNC_STAGES` flip-flops first. A tick in the cycle where the synchronised trip is seen is not counted.
- R4: A run whose count is below `MIN_TICKS` stores code 0.
- R5: When the count would exceed `MAX_TICKS`, the run ends on that tick without any trip and stores the all-ones code. This also covers a ramp that never trips.
- R6: If `sys_rst_active` is sampled high during a run, `ramp_run` falls at the next edge. No code is stored, `code_valid` stays 0 and the previous `tmo_code` is kept. The next run counts from zero.
- R7: The code is written at the edge where `ramp_run` falls at run end. `code_valid` rises exactly one clock later.
- R8: While `code_valid` is 1, `tmo_code` does not change, and further `tick` or `ramp_trip` activity has no effect.
- R9: Every run start clears `code_valid`, and `code_valid` is 0 whenever `ramp_run` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| tick | input | 1 | One-cycle strobe of the watchdog time base |
| sys_rst_active | input | 1 | High while the system reset output is asserted |
| ramp_trip | input | 1 | Asynchronous ramp comparator output, high once threshold is crossed |
| ramp_run | output | 1 | 1 lets the ramp charge, 0 discharges it |
| tmo_code | output | CODE_W | Stored timeout code: 0 = zero timeout, all ones = disabled |
| code_valid | output | 1 | Stored code belongs to the last completed run |

## Verification
The properties assume that the comparator output returns low while the ramp is discharged. They also assume that system reset stays asserted long enough to flush the trip synchroniser before the next release. Otherwise a stale trip could end a new run at once. The stimulus always drops `ramp_trip` before asserting `sys_rst_active` and holds reset for five cycles. It spaces tick pulses four cycles apart and raises the trip just after a tick. As a result, no tick lands inside the synchroniser delay, and the expected code is the exact number of pulses issued.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
   typedef enum logic [1:0] {
      WRC_IDLE = 2'd0,
      WRC_MEAS = 2'd1,
      WRC_DONE = 2'd2
   } wrc_state_e;
endpackage

// File: rtl/wrc_sync.sv
module wrc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("wrc_sync: STAGES must lie in 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_sync = d_async;
   end else if (STAGES == 1) begin : g_single
      logic flop_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flop_q <= 1'b0;
         else        flop_q <= d_async;
      end
      assign q_sync = flop_q;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
      assign q_sync = chain_q[STAGES-1];
   end
endmodule

// File: rtl/wrc_tick_counter.sv
module wrc_tick_counter #(
   parameter int CNT_W = 8,
   parameter int TOP   = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             at_top
);
   localparam logic [CNT_W-1:0] TOP_V = CNT_W'(TOP);
   localparam logic [CNT_W-1:0] SAT_V = CNT_W'(TOP + 1);

   if ((TOP + 1) >= (2 ** CNT_W)) begin : g_bad_width
      $error("wrc_tick_counter: CNT_W too narrow for TOP+1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (clear)                      cnt_q <= '0;
      else if (inc && (cnt_q != SAT_V))    cnt_q <= cnt_q + 1'b1;
   end

   assign count  = cnt_q;
   assign at_top = (cnt_q == TOP_V);
endmodule

// File: rtl/wrc_classifier.sv
module wrc_classifier #(
   parameter int CNT_W     = 8,
   parameter int CODE_W    = 8,
   parameter int MIN_TICKS = 1,
   parameter int MAX_TICKS = 100
) (
   input  logic [CNT_W-1:0]  count,
   output logic [CODE_W-1:0] code
);
   localparam logic [CNT_W-1:0]  MAX_V = CNT_W'(MAX_TICKS);
   localparam logic [CODE_W-1:0] INF_V = '1;

   logic too_short;
   logic too_long;

   if (MIN_TICKS > 0) begin : g_min_check
      localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_TICKS);
      assign too_short = (count < MIN_V);
   end else begin : g_no_min
      assign too_short = 1'b0;
   end

   assign too_long = (count > MAX_V);

   always_comb begin
      if (too_short)      code = '0;
      else if (too_long)  code = INF_V;
      else                code = CODE_W'(count);
   end
endmodule

// File: rtl/wrc_seq.sv
module wrc_seq
   import wrc_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_rst_active,
   input  logic              trip_s,
   input  logic              tick,
   input  logic              cnt_at_top,
   input  logic [CODE_W-1:0] cls_code,
   output logic              meas,
   output logic [CODE_W-1:0] code_q,
   output logic              valid_q
);
   localparam logic [CODE_W-1:0] INF_V = '1;

   wrc_state_e st_q;
   logic       latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= WRC_IDLE;
         code_q  <= '0;
         valid_q <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         latch_q <= 1'b0;
         if (latch_q) valid_q <= 1'b1;
         case (st_q)
            WRC_IDLE: begin
               if (!sys_rst_active) begin
                  st_q    <= WRC_MEAS;
                  valid_q <= 1'b0;
               end
            end
            WRC_MEAS: begin
               if (sys_rst_active) begin
                  st_q <= WRC_IDLE;
               end else if (trip_s) begin
                  code_q  <= cls_code;
                  latch_q <= 1'b1;
                  st_q    <= WRC_DONE;
               end else if (tick && cnt_at_top) begin
                  code_q  <= INF_V;
                  latch_q <= 1'b1;
                  st_q    <= WRC_DONE;
               end
            end
            WRC_DONE: begin
               if (sys_rst_active) st_q <= WRC_IDLE;
            end
            default: st_q <= WRC_IDLE;
         endcase
      end
   end

   assign meas = (st_q == WRC_MEAS);
endmodule

// File: rtl/wrc_ramp_capture.sv
module wrc_ramp_capture #(
   parameter int CODE_W      = 16,
   parameter int MIN_TICKS   = 1,
   parameter int MAX_TICKS   = 46250,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              sys_rst_active,
   input  logic              ramp_trip,
   output logic              ramp_run,
   output logic [CODE_W-1:0] tmo_code,
   output logic              code_valid
);
   localparam int CNT_W = $clog2(MAX_TICKS + 2);

   if (MIN_TICKS < 0 || MIN_TICKS > MAX_TICKS) begin : g_bad_min
      $error("wrc_ramp_capture: MIN_TICKS must lie in 0..MAX_TICKS");
   end
   if (MAX_TICKS >= (2 ** CODE_W) - 1) begin : g_bad_code
      $error("wrc_ramp_capture: CODE_W cannot separate MAX_TICKS from the disabled code");
   end

   logic              trip_s;
   logic              meas;
   logic [CNT_W-1:0]  count;
   logic              at_top;
   logic [CODE_W-1:0] cls_code;

   wrc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (ramp_trip),
      .q_sync  (trip_s)
   );

   wrc_tick_counter #(.CNT_W(CNT_W), .TOP(MAX_TICKS)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (!meas),
      .inc    (meas && tick && !trip_s),
      .count  (count),
      .at_top (at_top)
   );

   wrc_classifier #(
      .CNT_W(CNT_W), .CODE_W(CODE_W),
      .MIN_TICKS(MIN_TICKS), .MAX_TICKS(MAX_TICKS)
   ) u_cls (
      .count (count),
      .code  (cls_code)
   );

   wrc_seq #(.CODE_W(CODE_W)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .sys_rst_active (sys_rst_active),
      .trip_s         (trip_s),
      .tick           (tick),
      .cnt_at_top     (at_top),
      .cls_code       (cls_code),
      .meas           (meas),
      .code_q         (tmo_code),
      .valid_q        (code_valid)
   );

   assign ramp_run = meas;
endmodule

// File: rtl/wrc_capture_checker.sv
module wrc_capture_checker #(
   parameter int CODE_W    = 16,
   parameter int MIN_TICKS = 1,
   parameter int MAX_TICKS = 46250
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sys_rst_active,
   input logic              ramp_run,
   input logic [CODE_W-1:0] tmo_code,
   input logic              code_valid
);
   localparam logic [CODE_W-1:0] INF_V = '1;
   localparam logic [CODE_W-1:0] MIN_V = CODE_W'(MIN_TICKS);
   localparam logic [CODE_W-1:0] MAX_V = CODE_W'(MAX_TICKS);

   AST_START_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ramp_run && !sys_rst_active && !code_valid && $past(sys_rst_active)) |=> ramp_run); // R2

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid |-> (tmo_code == '0 || tmo_code == INF_V ||
                      (tmo_code >= MIN_V && tmo_code <= MAX_V))); // R3

   AST_ABORT_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_active |=> !ramp_run); // R6

   AST_ABORT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ramp_run) && $past(sys_rst_active)) |=> !code_valid); // R6

   AST_VALID_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ramp_run) && !$past(sys_rst_active)) |=> code_valid); // R7

   AST_VALID_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(code_valid) |-> !$past(ramp_run)); // R7

   AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid |=> $stable(tmo_code)); // R8

   AST_NO_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_run |-> !code_valid); // R9
endmodule

bind wrc_ramp_capture wrc_capture_checker #(
   .CODE_W(CODE_W), .MIN_TICKS(MIN_TICKS), .MAX_TICKS(MAX_TICKS)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sys_rst_active (sys_rst_active),
   .ramp_run       (ramp_run),
   .tmo_code       (tmo_code),
   .code_valid     (code_valid)
);

// File: tb/test_wrc_ramp_capture.sv
module test_wrc_ramp_capture;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int CODE_W = 8;
   localparam int MINT   = 3;
   localparam int MAXT   = 40;
   localparam int INF    = 255;
   localparam int VEC_N  = 9;
   localparam int VEC_TICKS [VEC_N] = '{0, 2, 3, 4, 17, 39, 40, 41, 45};
   localparam int VEC_EXP   [VEC_N] = '{0, 0, 3, 4, 17, 39, 40, INF, INF};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic sys_rst_active = 1'b1;
   logic ramp_trip = 1'b0;
   logic ramp_run;
   logic [CODE_W-1:0] tmo_code;
   logic code_valid;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #2.5 clk = ~clk;

   wrc_ramp_capture #(
      .CODE_W(CODE_W), .MIN_TICKS(MINT), .MAX_TICKS(MAXT), .SYNC_STAGES(2)
   ) i_wrc_ramp_capture (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sys_rst_active(sys_rst_active),
      .ramp_trip(ramp_trip), .ramp_run(ramp_run), .tmo_code(tmo_code),
      .code_valid(code_valid)
   );

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
         summary();
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic give_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         @(negedge clk);
         @(negedge clk);
      end
   endtask

   task automatic restart(input string req);
      @(negedge clk); ramp_trip = 1'b0; sys_rst_active = 1'b1;
      repeat (5) @(negedge clk);
      sys_rst_active = 1'b0;
      @(negedge clk);
      check(ramp_run == 1'b1, {req, " ramp_run"}, int'(ramp_run), 1);
      check(code_valid == 1'b0, {req, " code_valid"}, int'(code_valid), 0);
   endtask

   task automatic wait_valid(input string req);
      int guard = 0;
      while (!code_valid && guard < 40) begin
         @(negedge clk);
         guard++;
      end
      check(code_valid == 1'b1, {req, " valid reached"}, int'(code_valid), 1);
   endtask

   initial begin
      // R1: reset state
      repeat (4) @(negedge clk);
      check(ramp_run == 1'b0 && code_valid == 1'b0 && tmo_code == '0,
            "R1 in reset", int'(tmo_code), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(ramp_run == 1'b0 && code_valid == 1'b0 && tmo_code == '0,
            "R1 idle under system reset", int'(ramp_run), 0);

      // R2: release starts a run
      sys_rst_active = 1'b0;
      @(negedge clk);
      check(ramp_run == 1'b1, "R2 run starts", int'(ramp_run), 1);

      // R3 R4 R5 R9: table of tick counts
      for (int v = 0; v < VEC_N; v++) begin
         restart("R9 table start");
         give_ticks(VEC_TICKS[v]);
         @(negedge clk); ramp_trip = 1'b1;
         wait_valid("R3 table");
         check(int'(tmo_code) == VEC_EXP[v],
               (VEC_EXP[v] == 0) ? "R4 short code" :
               (VEC_EXP[v] == INF) ? "R5 long code" : "R3 tick code",
               int'(tmo_code), VEC_EXP[v]);
      end

      // R7: exact timing of latch and valid
      restart("R9 before R7");
      give_ticks(10);
      @(negedge clk); ramp_trip = 1'b1;
      begin
         int guard = 0;
         while (ramp_run && guard < 20) begin
            @(negedge clk);
            guard++;
         end
      end
      check(code_valid == 1'b0, "R7 valid low on latch edge", int'(code_valid), 0);
      check(int'(tmo_code) == 10, "R7 code on latch edge", int'(tmo_code), 10);
      @(negedge clk);
      check(code_valid == 1'b1, "R7 valid one cycle later", int'(code_valid), 1);

      // R8: activity after completion is ignored
      give_ticks(5);
      ramp_trip = 1'b0; @(negedge clk); ramp_trip = 1'b1;
      repeat (4) @(negedge clk);
      check(int'(tmo_code) == 10 && code_valid == 1'b1, "R8 code held",
            int'(tmo_code), 10);
      check(ramp_run == 1'b0, "R8 ramp stays discharged", int'(ramp_run), 0);

      // R6: abort keeps old code, next run counts from zero
      restart("R9 before R6");
      give_ticks(7);
      @(negedge clk); sys_rst_active = 1'b1;
      @(negedge clk);
      check(ramp_run == 1'b0, "R6 ramp off after abort", int'(ramp_run), 0);
      check(code_valid == 1'b0, "R6 no valid after abort", int'(code_valid), 0);
      check(int'(tmo_code) == 10, "R6 old code kept", int'(tmo_code), 10);
      repeat (5) @(negedge clk);
      sys_rst_active = 1'b0;
      @(negedge clk);
      give_ticks(5);
      @(negedge clk); ramp_trip = 1'b1;
      wait_valid("R6 rerun");
      check(int'(tmo_code) == 5, "R6 rerun counts from zero", int'(tmo_code), 5);

      // R5: ramp never trips
      restart("R9 before R5");
      give_ticks(MAXT + 1);
      wait_valid("R5 no trip");
      check(int'(tmo_code) == INF, "R5 grounded ramp disabled", int'(tmo_code), INF);
      check(ramp_run == 1'b0, "R5 ramp discharged", int'(ramp_run), 0);

      summary();
   end
endmodule